// File: doc/BRIEF.md
# Bus-Matching Endian Read Port

This block sits between a FIFO read interface that holds 36-bit long words and a narrower read port. Depending on two static inputs, each long word leaves the port as one 36-bit unit, two 18-bit units or four 9-bit units. A holding register keeps the long word that is being delivered. An index records which piece the port shows next.

The delivery order inside a long word is fixed at reset. An order-select input is captured while reset is active. When it is high, the most significant piece leaves first. When it is low, the least significant piece leaves first. The block pops the FIFO in two cases: when the holding register is empty, or in the same cycle as the last piece of the current word is read. When the FIFO has data, words therefore follow each other with no idle cycle. When it has none, no word is fetched early.

The FIFO uses show-ahead data: `src_data` is valid whenever `src_empty` is low, and it is consumed at the clock edge where `src_pop` is high. The width-mode inputs must stay constant while the block is out of reset.

Top module: `bm_read_port`

## Requirements
- R1: With `bus_match` low, every read delivers the whole 36-bit long word on `rd_data[35:0]`, so one read consumes one long word.
- R2: With `bus_match` high and `size_sel` low (word mode), each long word is delivered as two 18-bit pieces on `rd_data[17:0]`, with `rd_data[35:18]` zero. The pieces are bits 35:18 and bits 17:0.
- R3: With `bus_match` high and `size_sel` high (byte mode), each long word is delivered as four 9-bit pieces on `rd_data[8:0]`, with `rd_data[35:9]` zero. The pieces are bits 35:27, 26:18, 17:9 and 8:0.
- R4: If `order_sel` is high while reset is active, the pieces of each word are delivered from the most significant piece to the least significant.
- R5: If `order_sel` is low while reset is active, the pieces of each word are delivered from the least significant piece to the most significant.
- R6: Changes on `order_sel` after reset has been released have no effect on the delivery order.
- R7: `src_pop` is high only when `src_empty` is low and either no piece is held or the final held piece is read in that cycle.
- R8: `rd_ready` is high exactly when at least one unread piece is held. It is low during reset and after reset until the first word is popped.
- R9: A read with `rd_en` high while `rd_ready` is low has no effect. A cycle with `rd_ready` high and `rd_en` low keeps `rd_data` and `rd_ready` unchanged.
- R10: When the FIFO is not empty as the final piece is read, the next word's first piece is shown in the following cycle, with no cycle where `rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the port and the FIFO read side |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_match | input | 1 | Low: full 36-bit width. High: narrow width chosen by size_sel. Must stay static |
| size_sel | input | 1 | In narrow mode, high selects 9-bit units and low selects 18-bit units. Must stay static |
| order_sel | input | 1 | Captured during reset. High: most significant piece first. Low: least significant piece first |
| src_data | input | 36 | Show-ahead long word from the FIFO |
| src_empty | input | 1 | FIFO holds no word |
| src_pop | output | 1 | Consume the FIFO's front word at this clock edge |
| rd_en | input | 1 | Read request from the port side |
| rd_ready | output | 1 | A piece is available on rd_data |
| rd_data | output | 36 | Current piece, right-aligned and zero-extended |

## Verification
The hardest case to reach is the refill decision on the final piece of a word. The FIFO may or may not hold a new word in exactly that cycle, and that decides between a seamless follow-on and a drop of `rd_ready`. The bench runs every width and order setting with read requests and FIFO pushes each drawn independently at random per cycle. It also includes phases with a saturated read request and a sparse source. Together these repeatedly produce both an empty FIFO and a freshly arrived word at the moment the last piece leaves. A cycle-exact behavioural model predicts `src_pop`, `rd_ready` and `rd_data` in every cycle.

// File: rtl/bm_read_port_pkg.sv
package bm_read_port_pkg;

  localparam int unsigned LONG_W = 36;

  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_WORD = 2'd1,
    MODE_BYTE = 2'd2
  } width_mode_e;

  function automatic width_mode_e decode_mode(input logic bm, input logic sz);
    if (!bm)     return MODE_LONG;
    else if (sz) return MODE_BYTE;
    else         return MODE_WORD;
  endfunction

  // index of the final piece of a long word in each mode
  function automatic logic [1:0] final_index(input width_mode_e m);
    case (m)
      MODE_BYTE: return 2'd3;
      MODE_WORD: return 2'd1;
      default:   return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/bm_piece_ctrl.sv
module bm_piece_ctrl
  import bm_read_port_pkg::*;
#(
  parameter int unsigned DW = LONG_W
) (
  input  logic          clk,
  input  logic          rst_int_n,
  input  width_mode_e   mode,
  input  logic [DW-1:0] src_data,
  input  logic          src_empty,
  input  logic          rd_en,
  output logic          src_pop,
  output logic          hold_valid,
  output logic [1:0]    piece_idx,
  output logic [DW-1:0] hold_word
);
  logic          valid_q, valid_d;
  logic [1:0]    idx_q, idx_d;
  logic [DW-1:0] word_q, word_d;
  logic          take, at_last, load, word_en;

  always_comb begin
    take    = rd_en && valid_q;
    at_last = (idx_q == final_index(mode));
    load    = !src_empty && (!valid_q || (take && at_last));
    word_en = load;
    valid_d = valid_q;
    idx_d   = idx_q;
    word_d  = src_data;
    if (load) begin
      valid_d = 1'b1;
      idx_d   = 2'd0;
    end else if (take) begin
      if (at_last) begin
        valid_d = 1'b0;
        idx_d   = 2'd0;
      end else begin
        idx_d   = idx_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      idx_q   <= 2'd0;
    end else begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  // data path: clock enable only, no reset needed
  always_ff @(posedge clk) begin
    if (word_en) word_q <= word_d;
  end

  assign src_pop    = load;
  assign hold_valid = valid_q;
  assign piece_idx  = idx_q;
  assign hold_word  = word_q;
endmodule

// File: rtl/bm_piece_mux.sv
module bm_piece_mux
  import bm_read_port_pkg::*;
#(
  parameter int unsigned DW = LONG_W
) (
  input  width_mode_e   mode,
  input  logic          msb_first,
  input  logic [1:0]    piece_idx,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] piece
);
  localparam int unsigned NB   = 4;
  localparam int unsigned NW   = 2;
  localparam int unsigned BW   = DW / NB;
  localparam int unsigned WW   = DW / NW;

  logic [BW-1:0] byte_slot [NB];
  logic [WW-1:0] word_slot [NW];
  logic [1:0]    b_sel;
  logic          w_sel;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      assign byte_slot[g] = word[g*BW +: BW];
    end
    for (g = 0; g < NW; g++) begin : g_word
      assign word_slot[g] = word[g*WW +: WW];
    end
  endgenerate

  always_comb begin
    b_sel = msb_first ? (2'd3 - piece_idx) : piece_idx;
    w_sel = msb_first ? ~piece_idx[0] : piece_idx[0];
    piece = '0;
    case (mode)
      MODE_BYTE: piece[BW-1:0] = byte_slot[b_sel];
      MODE_WORD: piece[WW-1:0] = word_slot[w_sel];
      default:   piece         = word;
    endcase
  end
endmodule

// File: rtl/bm_read_port.sv
module bm_read_port
  import bm_read_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_match,
  input  logic        size_sel,
  input  logic        order_sel,
  input  logic [35:0] src_data,
  input  logic        src_empty,
  output logic        src_pop,
  input  logic        rd_en,
  output logic        rd_ready,
  output logic [35:0] rd_data
);
  localparam int unsigned DW = LONG_W;

  logic          rst_int_n;
  logic          msb_first_q;
  width_mode_e   mode;
  logic          hold_valid;
  logic [1:0]    piece_idx;
  logic [DW-1:0] hold_word;

  bm_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  // order select is captured on every edge inside reset, then frozen
  always_ff @(posedge clk) begin
    if (!rst_int_n) msb_first_q <= order_sel;
  end

  assign mode = decode_mode(bus_match, size_sel);

  bm_piece_ctrl #(.DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_int_n  (rst_int_n),
    .mode       (mode),
    .src_data   (src_data),
    .src_empty  (src_empty),
    .rd_en      (rd_en),
    .src_pop    (src_pop),
    .hold_valid (hold_valid),
    .piece_idx  (piece_idx),
    .hold_word  (hold_word)
  );

  bm_piece_mux #(.DW(DW)) u_mux (
    .mode      (mode),
    .msb_first (msb_first_q),
    .piece_idx (piece_idx),
    .word      (hold_word),
    .piece     (rd_data)
  );

  assign rd_ready = hold_valid;
endmodule

// File: rtl/bm_read_port_chk.sv
module bm_read_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_match,
  input logic        size_sel,
  input logic        src_empty,
  input logic        src_pop,
  input logic        rd_en,
  input logic        rd_ready,
  input logic [35:0] rd_data
);
  // R7
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> !src_empty);

  // R7
  pop_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> (!rd_ready || rd_en));

  // R8
  ready_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |=> rd_ready);

  // R8
  no_ready_from_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready && src_empty) |=> !rd_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_en) |=> (rd_ready && $stable(rd_data)));

  // R2
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_match && !size_sel && rd_ready) |-> (rd_data[35:18] == '0));

  // R3
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_match && size_sel && rd_ready) |-> (rd_data[35:9] == '0));
endmodule

bind bm_read_port bm_read_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_match (bus_match),
  .size_sel  (size_sel),
  .src_empty (src_empty),
  .src_pop   (src_pop),
  .rd_en     (rd_en),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data)
);

// File: tb/tb_bm_read_port.sv
`timescale 1ns/1ps
module tb_bm_read_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_match, size_sel, order_sel;
  logic [35:0] src_data;
  logic        src_empty;
  logic        src_pop;
  logic        rd_en;
  logic        rd_ready;
  logic [35:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [35:0] src_q[$];
  logic [35:0] piece_q[$];
  bit          cfg_msb;

  always #4 clk = ~clk;

  bm_read_port dut (
    .clk(clk), .rst_n(rst_n), .bus_match(bus_match), .size_sel(size_sel),
    .order_sel(order_sel), .src_data(src_data), .src_empty(src_empty),
    .src_pop(src_pop), .rd_en(rd_en), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  function automatic string data_tag();
    string t;
    t = !bus_match ? "R1" : (size_sel ? "R3" : "R2");
    return {t, cfg_msb ? "/R4" : "/R5"};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // split a long word into its expected pieces in delivery order
  task automatic expand(input logic [35:0] w);
    int n, sz;
    n  = !bus_match ? 1 : (size_sel ? 4 : 2);
    sz = 36 / n;
    for (int k = 0; k < n; k++) begin
      int slot;
      logic [35:0] p;
      slot = cfg_msb ? (n - 1 - k) : k;
      p = (w >> (slot * sz)) & ((36'd1 << sz) - 36'd1);
      if (n == 1) p = w;
      piece_q.push_back(p);
    end
  endtask

  task automatic step(input bit rd, input bit push, input logic [35:0] w);
    bit take, last, pop;
    logic [35:0] pw;
    if (push) src_q.push_back(w);
    src_empty = (src_q.size() == 0);
    src_data  = src_empty ? 36'd0 : src_q[0];
    rd_en     = rd;
    #1;
    check("R8", {35'd0, rd_ready}, {35'd0, piece_q.size() != 0});
    if (piece_q.size() != 0) check(data_tag(), rd_data, piece_q[0]);
    take = rd && (piece_q.size() != 0);
    last = (piece_q.size() == 1);
    pop  = (src_q.size() != 0) && ((piece_q.size() == 0) || (take && last));
    // R7 R10: pop decision, including the seamless refill on the last piece
    check(take && last ? "R10" : "R7", {35'd0, src_pop}, {35'd0, pop});
    if (take) void'(piece_q.pop_front());       // R9: no take when not ready
    if (pop) begin
      pw = src_q.pop_front();
      expand(pw);
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input bit bm, input bit sz, input bit msb);
    rst_n = 1'b0;
    bus_match = bm; size_sel = sz; order_sel = msb; cfg_msb = msb;
    rd_en = 1'b0; src_empty = 1'b1; src_data = 36'd0;
    src_q.delete(); piece_q.delete();
    repeat (3) @(negedge clk);
    check("R8", {34'd0, rd_ready, src_pop}, 36'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", {35'd0, rd_ready}, 36'd0);
    order_sel = ~msb; // R6: later changes must not alter the order
  endtask

  function automatic logic [35:0] rnd36();
    return {$urandom, $urandom} & 36'hF_FFFF_FFFF;
  endfunction

  task automatic run_phase(input bit bm, input bit sz, input bit msb);
    do_reset(bm, sz, msb);
    // directed: fixed pattern, reads stalled then saturated
    step(1'b1, 1'b1, 36'h8_1234_5678);  // R9: read while not ready
    step(1'b0, 1'b1, 36'h1_2345_6789);
    step(1'b0, 1'b1, 36'hA_BCDE_F012);
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 36'd0); // R10 back to back
    for (int i = 0; i < 250; i++) begin
      order_sel = $urandom_range(0, 1); // R6
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0), rnd36());
    end
    for (int i = 0; i < 150; i++)
      step(1'b1, ($urandom_range(0, 2) == 0), rnd36());
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 36'd0);
  endtask

  initial begin
    rst_n = 1'b1;
    bus_match = 1'b0; size_sel = 1'b0; order_sel = 1'b0;
    rd_en = 1'b0; src_empty = 1'b1; src_data = 36'd0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    run_phase(1'b0, 1'b0, 1'b1); // R1
    run_phase(1'b0, 1'b1, 1'b0); // R1
    run_phase(1'b1, 1'b0, 1'b1); // R2 R4
    run_phase(1'b1, 1'b0, 1'b0); // R2 R5
    run_phase(1'b1, 1'b1, 1'b1); // R3 R4
    run_phase(1'b1, 1'b1, 1'b0); // R3 R5
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule